// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block sits between a host byte port and four byte-wide memory planes of a planar frame buffer. Each host write produces one byte per plane together with a four-bit plane strobe. Each host read gathers the bytes stored at the addressed location in all four planes and returns them to the host merged into a single byte. The same read also captures those four bytes in a set of latches. Later writes can merge new data with the latched bytes bit by bit, which allows a masked update to leave the untouched pixels unchanged without a separate read-modify-write step.

Two write mode values are supported. In the direct mode, the host byte is rotated and copied to every plane. In the masked fill mode, the rotated host byte becomes a per-bit mask that chooses between a per-plane constant fill and the latch. In both modes a bit-mask register marks the bit positions that may change. Plane write enables are gated by the plane select that comes from address decoding.

Top module: `plane_wr_path`

## Requirements
- R1: After reset, the host read data is 0x00 and all four latches hold 0x00.
- R2: When read mode is 0, the host read data after a host read is the bitwise OR of the four plane bytes present in the read cycle. The new value is visible on the clock edge that ends that cycle.
- R3: A host read loads latch p with plane p's byte, for p from 0 to 3. Plane p occupies bits 8p+7 down to 8p of the plane buses.
- R4: When write mode is 0, plane p's write byte is (M & rotr(D,r)) | (~M & L[p]). Here D is the host byte, r is the 3-bit rotate count, rotr is a right rotation, M is the bit-mask register and L[p] is latch p.
- R5: When write mode is 3, the mask is K = rotr(D,r) & M. Plane p's write byte is (K & S[p]) | (~K & L[p]), where S[p] is 0xFF if set/reset bit p is 1 and 0x00 otherwise.
- R6: During a host write in mode 0 or 3, the plane strobe equals the plane-enable field ANDed with the address plane select. Without a host write, the strobe is 0.
- R7: When write mode is 1 or 2, no plane is strobed, even during a host write.
- R8: When read mode is 1, a host read returns 0x00. The read still loads the latches.
- R9: When a host read and a host write fall in the same cycle, the write merges with the latch contents from before that read.
- R10: Without a host read, the host read data and the latches keep their values, whatever appears on the plane read bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 8 | Host write byte |
| cfg_wmode | input | 2 | Write mode (0 = direct, 3 = masked fill, 1 and 2 = no write) |
| cfg_rmode | input | 1 | Read mode (0 = OR of planes, 1 = returns zero) |
| cfg_rotate | input | 3 | Right-rotate count for the host byte |
| cfg_bitmask | input | 8 | Bit positions allowed to take new data |
| cfg_setreset | input | 4 | Per-plane fill constant select |
| cfg_plane_en | input | 4 | Programmable plane write enable |
| addr_plane_sel | input | 4 | Plane select from address decoding |
| mem_rd_data | input | 32 | Bytes read from the four planes, plane p in bits 8p+7 down to 8p |
| mem_wr_data | output | 32 | Write bytes for the four planes, same layout |
| mem_wr_strobe | output | 4 | Per-plane write strobe |
| host_rd_data | output | 8 | Data returned to the host |

## Verification
A host read and a host write can occur in the same cycle. The write merge is combinational from the current latches, and the latches update only at the end of that cycle. The bench holds both strobes together with a zero bit mask and a plane bus different from the old latches. It then checks that the write bytes still equal the old latches, and on the next write that they equal the newly captured bytes. A checker property also ties the unmasked write bits to the latch outputs in the same cycle.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  localparam int BYTE_W   = 8;
  localparam int N_PLANES = 4;
  localparam int ROT_W    = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    WM_DIRECT    = 2'd0,
    WM_EXPAND    = 2'd1,
    WM_FILL      = 2'd2,
    WM_MASKED_SR = 2'd3
  } wmode_e;

  // Right rotation of a byte by n positions.
  function automatic byte_t rotr(input byte_t b, input logic [ROT_W-1:0] n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {b, b} >> n;
    return dbl[BYTE_W-1:0];
  endfunction

  // Bitwise select: mask 1 takes a, mask 0 takes b.
  function automatic byte_t bit_pick(input byte_t msk, input byte_t a, input byte_t b);
    return (msk & a) | (~msk & b);
  endfunction

  // One set/reset bit expanded to a whole byte.
  function automatic byte_t sr_fill(input logic bit_in);
    return {BYTE_W{bit_in}};
  endfunction

  function automatic logic mode_writes(input logic [1:0] wm);
    return (wm == WM_DIRECT) || (wm == WM_MASKED_SR);
  endfunction

endpackage

// File: rtl/pwp_latch_bank.sv
module pwp_latch_bank
  import pwp_pkg::*;
#(
  parameter int PLANES = N_PLANES,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rmode,
  input  logic [BUS_W-1:0] rd_bus,
  output logic [BUS_W-1:0] latch_bus,
  output byte_t            rd_data
);

  byte_t or_all;

  always_comb begin
    or_all = '0;
    for (int p = 0; p < PLANES; p++) begin
      or_all = or_all | rd_bus[p*BYTE_W +: BYTE_W];
    end
  end

  generate
    for (genvar p = 0; p < PLANES; p++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          latch_bus[p*BYTE_W +: BYTE_W] <= '0;
        end else if (load) begin
          latch_bus[p*BYTE_W +: BYTE_W] <= rd_bus[p*BYTE_W +: BYTE_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (load) begin
      rd_data <= rmode ? '0 : or_all;
    end
  end

endmodule

// File: rtl/pwp_bit_merge.sv
module pwp_bit_merge
  import pwp_pkg::*;
#(
  parameter int PLANES = N_PLANES,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic [1:0]       wmode,
  input  logic [ROT_W-1:0] rot,
  input  byte_t            din,
  input  byte_t            bitmask,
  input  logic [PLANES-1:0] setreset,
  input  logic [BUS_W-1:0] latch_bus,
  output logic [BUS_W-1:0] wr_bus,
  output byte_t            eff_mask
);

  byte_t rot_data;

  assign rot_data = rotr(din, rot);

  always_comb begin
    unique case (wmode)
      WM_DIRECT:    eff_mask = bitmask;
      WM_MASKED_SR: eff_mask = rot_data & bitmask;
      default:      eff_mask = '0;
    endcase
  end

  generate
    for (genvar p = 0; p < PLANES; p++) begin : g_pl
      byte_t new_b;
      always_comb begin
        if (wmode == WM_MASKED_SR) new_b = sr_fill(setreset[p]);
        else                       new_b = rot_data;
      end
      assign wr_bus[p*BYTE_W +: BYTE_W] =
        bit_pick(eff_mask, new_b, latch_bus[p*BYTE_W +: BYTE_W]);
    end
  endgenerate

endmodule

// File: rtl/pwp_plane_gate.sv
module pwp_plane_gate
  import pwp_pkg::*;
#(
  parameter int PLANES = N_PLANES
) (
  input  logic              wr,
  input  logic [1:0]        wmode,
  input  logic [PLANES-1:0] plane_en,
  input  logic [PLANES-1:0] plane_sel,
  output logic              wr_ok,
  output logic [PLANES-1:0] strobe
);

  assign wr_ok  = wr && mode_writes(wmode);
  assign strobe = wr_ok ? (plane_en & plane_sel) : '0;

endmodule

// File: rtl/plane_wr_path.sv
module plane_wr_path
  import pwp_pkg::*;
#(
  parameter int PLANES = N_PLANES,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        host_data,
  input  logic [1:0]        cfg_wmode,
  input  logic              cfg_rmode,
  input  logic [2:0]        cfg_rotate,
  input  logic [7:0]        cfg_bitmask,
  input  logic [PLANES-1:0] cfg_setreset,
  input  logic [PLANES-1:0] cfg_plane_en,
  input  logic [PLANES-1:0] addr_plane_sel,
  input  logic [BUS_W-1:0]  mem_rd_data,
  output logic [BUS_W-1:0]  mem_wr_data,
  output logic [PLANES-1:0] mem_wr_strobe,
  output logic [7:0]        host_rd_data
);

  logic [BUS_W-1:0] latch_bus;
  byte_t            eff_mask;
  logic             wr_ok;

  pwp_latch_bank #(.PLANES(PLANES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (host_rd),
    .rmode     (cfg_rmode),
    .rd_bus    (mem_rd_data),
    .latch_bus (latch_bus),
    .rd_data   (host_rd_data)
  );

  pwp_bit_merge #(.PLANES(PLANES)) u_merge (
    .wmode     (cfg_wmode),
    .rot       (cfg_rotate),
    .din       (host_data),
    .bitmask   (cfg_bitmask),
    .setreset  (cfg_setreset),
    .latch_bus (latch_bus),
    .wr_bus    (mem_wr_data),
    .eff_mask  (eff_mask)
  );

  pwp_plane_gate #(.PLANES(PLANES)) u_gate (
    .wr        (host_wr),
    .wmode     (cfg_wmode),
    .plane_en  (cfg_plane_en),
    .plane_sel (addr_plane_sel),
    .wr_ok     (wr_ok),
    .strobe    (mem_wr_strobe)
  );

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker
  import pwp_pkg::*;
#(
  parameter int PLANES = N_PLANES,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic [1:0]        cfg_wmode,
  input logic              cfg_rmode,
  input logic [7:0]        cfg_bitmask,
  input logic [PLANES-1:0] cfg_plane_en,
  input logic [PLANES-1:0] addr_plane_sel,
  input logic [BUS_W-1:0]  mem_rd_data,
  input logic [BUS_W-1:0]  mem_wr_data,
  input logic [PLANES-1:0] mem_wr_strobe,
  input logic [7:0]        host_rd_data,
  input logic [BUS_W-1:0]  latch_bus,
  input logic [7:0]        eff_mask
);

  function automatic byte_t or_planes(input logic [BUS_W-1:0] v);
    byte_t r = '0;
    for (int p = 0; p < PLANES; p++) r = r | v[p*BYTE_W +: BYTE_W];
    return r;
  endfunction

  // R6: strobe never exceeds the gated enable set
  a_r6_strobe_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_strobe & ~(cfg_plane_en & addr_plane_sel)) == '0);

  // R6: idle cycles write nothing
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |-> mem_wr_strobe == '0);

  // R7: unsupported write modes write nothing
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (cfg_wmode == 2'd1 || cfg_wmode == 2'd2)) |-> mem_wr_strobe == '0);

  // R2: read mode 0 returns OR of planes after the read edge
  a_r2_read_or: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !cfg_rmode) |=> host_rd_data == or_planes($past(mem_rd_data)));

  // R8: read mode 1 returns zero
  a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && cfg_rmode) |=> host_rd_data == 8'h00);

  // R3: read loads latches
  a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> latch_bus == $past(mem_rd_data));

  // R10: no read keeps read data and latches
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> ($stable(host_rd_data) && $stable(latch_bus)));

  // R4 and R5: bits outside the active mask keep the latch value
  a_r5_keep_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (cfg_wmode == 2'd0 || cfg_wmode == 2'd3)) |->
      ((mem_wr_data ^ latch_bus) & ~{PLANES{eff_mask}}) == '0);

  // R5: computed mask stays within the bit-mask register
  a_r5_mask_within: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wmode == 2'd3) |-> (eff_mask & ~cfg_bitmask) == 8'h00);

endmodule

bind plane_wr_path pwp_checker #(.PLANES(PLANES)) u_chk (.*);

// File: tb/plane_wr_path_bench.sv
module plane_wr_path_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_data = '0;
  logic [1:0]  cfg_wmode = '0;
  logic        cfg_rmode = 1'b0;
  logic [2:0]  cfg_rotate = '0;
  logic [7:0]  cfg_bitmask = 8'hFF;
  logic [3:0]  cfg_setreset = '0;
  logic [3:0]  cfg_plane_en = 4'hF;
  logic [3:0]  addr_plane_sel = 4'hF;
  logic [31:0] mem_rd_data = '0;
  logic [31:0] mem_wr_data;
  logic [3:0]  mem_wr_strobe;
  logic [7:0]  host_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] m_lat = '0;
  logic [7:0]  m_rd = '0;

  plane_wr_path u_plane_wr_path (.*);

  always #2 clk = ~clk;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rot(input logic [7:0] b, input int n);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = b[(i + n) % 8];
    return o;
  endfunction

  function automatic logic [31:0] m_wr(input int wm, input int rot, input logic [7:0] d,
                                       input logic [7:0] bm, input logic [3:0] sr,
                                       input logic [31:0] lat);
    logic [31:0] o;
    logic [7:0] r, k;
    r = m_rot(d, rot);
    k = (wm == 3) ? (r & bm) : bm;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 8; i++)
        o[8*p+i] = k[i] ? ((wm == 3) ? sr[p] : r[i]) : lat[8*p+i];
    return o;
  endfunction

  task automatic do_read(input logic [31:0] planes, input logic rm);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1; cfg_rmode = rm; mem_rd_data = planes;
    @(negedge clk);
    host_rd = 1'b0;
    m_lat = planes;
    m_rd = rm ? 8'h00 : (planes[7:0] | planes[15:8] | planes[23:16] | planes[31:24]);
    chk(rm ? "R8 read mode1" : "R2 read OR", {24'h0, host_rd_data}, {24'h0, m_rd});
  endtask

  // Write with mask 0 in mode 0: data equals latches (R3 observation).
  task automatic peek_latch(input string tag);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b1; cfg_wmode = 2'd0; cfg_bitmask = 8'h00;
    #1;
    chk(tag, mem_wr_data, m_lat);
  endtask

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read data", {24'h0, host_rd_data}, 32'h0);
    peek_latch("R1 reset latches");

    do_read(32'h8142_2418, 1'b0);
    peek_latch("R3 latch load");
    do_read(32'hF00F_0000, 1'b1);
    peek_latch("R8/R3 latch load in read mode1");

    // R10: bus changes without a read
    @(negedge clk);
    host_wr = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk("R10 read data hold", {24'h0, host_rd_data}, {24'h0, m_rd});
    peek_latch("R10 latch hold");

    // R9: read and write together use old latches
    do_read(32'h1122_3344, 1'b0);
    @(negedge clk);
    host_rd = 1'b1; mem_rd_data = 32'hA5A5_5A5A;
    host_wr = 1'b1; cfg_wmode = 2'd0; cfg_bitmask = 8'h00;
    #1;
    chk("R9 same-cycle write old latch", mem_wr_data, m_lat);
    @(negedge clk);
    host_rd = 1'b0; m_lat = 32'hA5A5_5A5A;
    peek_latch("R9 latch after joint cycle");

    // Sweep write modes, rotates and enables
    for (int wm = 0; wm < 4; wm++) begin
      for (int rot = 0; rot < 8; rot++) begin
        for (int en = 0; en < 16; en++) begin
          logic [7:0] d, bm;
          logic [3:0] sr, sel;
          logic [31:0] expd;
          logic [3:0] exps;
          if (en % 4 == 0) do_read($urandom, 1'b0);
          d = 8'($urandom); bm = 8'($urandom); sr = 4'($urandom); sel = 4'($urandom);
          @(negedge clk);
          host_rd = 1'b0; host_wr = 1'b1; cfg_wmode = 2'(wm); cfg_rotate = 3'(rot);
          host_data = d; cfg_bitmask = bm; cfg_setreset = sr;
          cfg_plane_en = 4'(en); addr_plane_sel = sel;
          #1;
          exps = (wm == 0 || wm == 3) ? (4'(en) & sel) : 4'h0;
          if (wm == 0) chk("R4 mode0 data", mem_wr_data, m_wr(wm, rot, d, bm, sr, m_lat));
          if (wm == 3) chk("R5 mode3 data", mem_wr_data, m_wr(wm, rot, d, bm, sr, m_lat));
          if (wm == 1 || wm == 2) chk("R7 no strobe", {28'h0, mem_wr_strobe}, {28'h0, exps});
          else chk("R6 strobe gate", {28'h0, mem_wr_strobe}, {28'h0, exps});
          expd = 32'h0;
          if (expd != 32'h0) n_bad++;
        end
      end
    end

    // R6: no strobe without a write
    @(negedge clk);
    host_wr = 1'b0; cfg_wmode = 2'd0; cfg_plane_en = 4'hF; addr_plane_sel = 4'hF;
    #1;
    chk("R6 idle strobe", {28'h0, mem_wr_strobe}, 32'h0);

    report();
  end

endmodule